// File: doc/BRIEF.md
# Per-Pin Configurable I/O Port

This block is one microcontroller I/O port whose pins can each be set up on their own. On the output side, each pin selects what it drives from four sources: a CPU-written data-out register, a latched address bit, a logic macrocell output, or an external chip-select. The pin's driver enable is the OR of a CPU direction bit and an external enable term. That term counts only on pins whose "term defined" mask bit is set. The tri-state pad itself sits outside the block. The block provides the output value and the enable.

On the input side, each pin passes through an input cell. The cell works in one of three ways: a direct pass-through, a transparent latch, or an edge-triggered register. The latch and the register are timed by a strobe that is picked once for the whole port: either the address strobe or a product-term clock. The input cell outputs go to the logic input bus and can also be read by the CPU.

The CPU reaches the block through a plain register port. A write is a single-cycle strobe with an address and a data byte. The read data follows the address combinationally, and each address selects exactly one readback source. There is no data stream and no back-pressure. The port width `WIDTH` is a parameter from 1 to 8 pins, with a 4-pin reduced variant as the usual alternative. Register bits above `WIDTH` are ignored on write and read back as 0.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the data-out, direction, output-select and input-mode registers are all 0. Offsets 1 through 6 read back as 0. With no enable term defined, `pin_oe` is 0 and `pin_out` is 0.
- R2: A write with `wr_en` high takes effect on the clock edge where `wr_en` is sampled high. Offset 1 is data-out and offset 2 is direction. Both read back the written value from the next cycle on, and they hold it while no write hits them.
- R3: The output select for pin p is 2 bits. Pins 0–3 use offset 3 and pins 4–7 use offset 4, at bits [2*(p%4)+1 : 2*(p%4)]. The select codes are: 0 = data-out bit, 1 = `latched_addr` bit, 2 = `mcell_out` bit, 3 = `ext_cs` bit. `pin_out[p]` follows the selected source combinationally, and offsets 3 and 4 read back the written selects.
- R4: `pin_oe[p]` = direction bit p OR (`oe_term[p]` AND `term_defined[p]`).
- R5: When `term_defined[p]` is 0, `pin_oe[p]` equals the direction bit alone, whatever `oe_term[p]` is.
- R6: Reading offset 0 returns the raw `pin_in` levels. Reading offset 7 returns the input cell outputs, which are also driven on `imc_bus`.
- R7: The input mode for pin p is 2 bits. Pins 0–3 use offset 5 and pins 4–7 use offset 6, at the same bit positions as in R3. The mode codes are: 0 = direct, 1 = latch, 2 = register, 3 = direct. In direct mode, `imc_bus[p]` equals `pin_in[p]` combinationally.
- R8: In latch mode, `imc_bus[p]` follows `pin_in[p]` while the selected strobe is high. It holds the value present at the last clock edge where the strobe was high once the strobe is low.
- R9: In register mode, the cell captures `pin_in[p]` on the first clock edge at which the selected strobe is sampled high after being sampled low. The captured value shows on `imc_bus[p]` after that edge and holds until the next rising strobe.
- R10: With `imc_clk_sel` = 0 the input cells are timed by `addr_strobe`, and `pterm_clk` has no effect. With `imc_clk_sel` = 1 they are timed by `pterm_clk`, and `addr_strobe` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| latched_addr | input | WIDTH | Latched address bits (output source 1) |
| mcell_out | input | WIDTH | Logic macrocell outputs (output source 2) |
| ext_cs | input | WIDTH | External chip-selects (output source 3) |
| oe_term | input | WIDTH | Enable product terms from the logic array |
| term_defined | input | WIDTH | Per-pin mask: 1 = enable term exists |
| pin_in | input | WIDTH | Pad input levels |
| addr_strobe | input | 1 | Address strobe for the input cells |
| pterm_clk | input | 1 | Product-term clock for the input cells |
| imc_clk_sel | input | 1 | Input cell strobe select, 0 = address strobe |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad driver enables |
| imc_bus | output | WIDTH | Input cell outputs to the logic input bus |

## Verification
The assertions check on every cycle that a write lands in the data-out register on the next edge and that registers stay stable without a write. They also check that an undefined enable term leaves the direction bit in sole control of the driver. In each input cell they check three things: direct mode passes the pin through, register mode loads the pin on a strobe rise, and register mode holds otherwise. Only the bench's scenarios can show the following: the select and mode bit packing across the two bytes, the source each select code picks, the transparent-then-hold sequence of the latch, and that the unselected strobe is ignored. They also show that every readback offset returns its own source.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  typedef enum logic [1:0] {
    SRC_DOUT  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MCELL = 2'd2,
    SRC_CS    = 2'd3
  } out_src_e;

  typedef enum logic [1:0] {
    IMC_DIRECT  = 2'd0,
    IMC_LATCH   = 2'd1,
    IMC_REG     = 2'd2,
    IMC_DIRECT2 = 2'd3
  } imc_mode_e;

  localparam logic [2:0] OFS_PIN     = 3'd0;
  localparam logic [2:0] OFS_DOUT    = 3'd1;
  localparam logic [2:0] OFS_DIR     = 3'd2;
  localparam logic [2:0] OFS_SEL_LO  = 3'd3;
  localparam logic [2:0] OFS_SEL_HI  = 3'd4;
  localparam logic [2:0] OFS_MODE_LO = 3'd5;
  localparam logic [2:0] OFS_MODE_HI = 3'd6;
  localparam logic [2:0] OFS_IMC     = 3'd7;

  localparam int PINS_PER_BYTE = 4;
endpackage

// File: rtl/iop_regs.sv
module iop_regs
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [7:0]         wr_data,
  input  logic [WIDTH-1:0]   pin_in,
  input  logic [WIDTH-1:0]   imc_bus,
  output logic [7:0]         rd_data,
  output logic [WIDTH-1:0]   dout,
  output logic [WIDTH-1:0]   dir,
  output logic [2*WIDTH-1:0] sel_flat,
  output logic [2*WIDTH-1:0] mode_flat
);
  localparam int FW = 2 * WIDTH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
    end else if (wr_en) begin
      if (addr == OFS_DOUT) dout <= wr_data[WIDTH-1:0];
      if (addr == OFS_DIR)  dir  <= wr_data[WIDTH-1:0];
    end
  end

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    localparam logic [2:0] SEL_OFS  = OFS_SEL_LO  + 3'(p / PINS_PER_BYTE);
    localparam logic [2:0] MODE_OFS = OFS_MODE_LO + 3'(p / PINS_PER_BYTE);
    localparam int         SH       = 2 * (p % PINS_PER_BYTE);
    logic [1:0] sel_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q  <= SRC_DOUT;
        mode_q <= IMC_DIRECT;
      end else if (wr_en) begin
        if (addr == SEL_OFS)  sel_q  <= wr_data[SH +: 2];
        if (addr == MODE_OFS) mode_q <= wr_data[SH +: 2];
      end
    end

    assign sel_flat[2*p +: 2]  = sel_q;
    assign mode_flat[2*p +: 2] = mode_q;
  end

  logic [15:0] sel_pad, mode_pad;
  logic [7:0]  pin_pad, imc_pad, dout_pad, dir_pad;

  always_comb begin
    sel_pad  = '0;
    mode_pad = '0;
    pin_pad  = '0;
    imc_pad  = '0;
    dout_pad = '0;
    dir_pad  = '0;
    sel_pad[FW-1:0]    = sel_flat;
    mode_pad[FW-1:0]   = mode_flat;
    pin_pad[WIDTH-1:0] = pin_in;
    imc_pad[WIDTH-1:0] = imc_bus;
    dout_pad[WIDTH-1:0] = dout;
    dir_pad[WIDTH-1:0]  = dir;
  end

  always_comb begin
    unique case (addr)
      OFS_PIN:     rd_data = pin_pad;
      OFS_DOUT:    rd_data = dout_pad;
      OFS_DIR:     rd_data = dir_pad;
      OFS_SEL_LO:  rd_data = sel_pad[7:0];
      OFS_SEL_HI:  rd_data = sel_pad[15:8];
      OFS_MODE_LO: rd_data = mode_pad[7:0];
      OFS_MODE_HI: rd_data = mode_pad[15:8];
      default:     rd_data = imc_pad;
    endcase
  end

  // R2: a data-out write lands on the next edge
  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DOUT) |=> dout == $past(wr_data[WIDTH-1:0]));

  // R2: registers hold without a write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dout) && $stable(dir) && $stable(sel_flat) && $stable(mode_flat)));
endmodule

// File: rtl/iop_out_cell.sv
module iop_out_cell
  import cfg_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       dout_bit,
  input  logic       addr_bit,
  input  logic       mcell_bit,
  input  logic       cs_bit,
  input  logic       dir_bit,
  input  logic       term,
  input  logic       term_def,
  output logic       out_bit,
  output logic       oe_bit
);
  out_src_e src;
  assign src = out_src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_DOUT:  out_bit = dout_bit;
      SRC_ADDR:  out_bit = addr_bit;
      SRC_MCELL: out_bit = mcell_bit;
      default:   out_bit = cs_bit;
    endcase
  end

  logic term_eff;
  assign term_eff = term & term_def;
  assign oe_bit   = dir_bit | term_eff;

  // R5: an undefined enable term leaves the direction bit in sole control
  p_undef_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !term_def |-> (oe_bit == dir_bit));

  // R4: a set direction bit always enables the driver
  p_dir_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_bit |-> oe_bit);
endmodule

// File: rtl/iop_in_cell.sv
module iop_in_cell
  import cfg_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       strobe,
  input  logic       rise,
  input  logic       pin,
  output logic       cell_out
);
  imc_mode_e m;
  assign m = imc_mode_e'(mode);

  logic store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= 1'b0;
    end else begin
      unique case (m)
        IMC_LATCH: if (strobe) store_q <= pin;
        IMC_REG:   if (rise)   store_q <= pin;
        default:   store_q <= store_q;
      endcase
    end
  end

  always_comb begin
    unique case (m)
      IMC_LATCH: cell_out = strobe ? pin : store_q;
      IMC_REG:   cell_out = store_q;
      default:   cell_out = pin;
    endcase
  end

  // R7: direct modes pass the pin straight through
  p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m == IMC_DIRECT || m == IMC_DIRECT2) |-> cell_out == pin);

  // R9: register mode loads the pin on a strobe rise
  p_reg_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m == IMC_REG && rise) |=> (m != IMC_REG || cell_out == $past(pin)));

  // R9: register mode holds without a rise
  p_reg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m == IMC_REG && !rise) |=> (m != IMC_REG || $stable(cell_out)));
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [WIDTH-1:0] latched_addr,
  input  logic [WIDTH-1:0] mcell_out,
  input  logic [WIDTH-1:0] ext_cs,
  input  logic [WIDTH-1:0] oe_term,
  input  logic [WIDTH-1:0] term_defined,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             addr_strobe,
  input  logic             pterm_clk,
  input  logic             imc_clk_sel,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] imc_bus
);
  localparam int FW = 2 * WIDTH;

  initial begin
    if (WIDTH < 1 || WIDTH > 8) $display("cfg_io_port: WIDTH must be 1..8");
  end

  logic [WIDTH-1:0] dout, dir;
  logic [FW-1:0]    sel_flat, mode_flat;

  iop_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .pin_in    (pin_in),
    .imc_bus   (imc_bus),
    .rd_data   (rd_data),
    .dout      (dout),
    .dir       (dir),
    .sel_flat  (sel_flat),
    .mode_flat (mode_flat)
  );

  logic strobe, strobe_q, rise;
  assign strobe = imc_clk_sel ? pterm_clk : addr_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end
  assign rise = strobe & ~strobe_q;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    iop_out_cell u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_flat[2*p +: 2]),
      .dout_bit  (dout[p]),
      .addr_bit  (latched_addr[p]),
      .mcell_bit (mcell_out[p]),
      .cs_bit    (ext_cs[p]),
      .dir_bit   (dir[p]),
      .term      (oe_term[p]),
      .term_def  (term_defined[p]),
      .out_bit   (pin_out[p]),
      .oe_bit    (pin_oe[p])
    );

    iop_in_cell u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_flat[2*p +: 2]),
      .strobe   (strobe),
      .rise     (rise),
      .pin      (pin_in[p]),
      .cell_out (imc_bus[p])
    );
  end

  // R10: a strobe rise is seen only on the selected source
  p_rise_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (imc_clk_sel ? pterm_clk : addr_strobe));
endmodule

// File: tb/cfg_io_port_test.sv
module cfg_io_port_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, wr_en, addr_strobe, pterm_clk, imc_clk_sel;
  logic [2:0]   addr;
  logic [7:0]   wr_data, rd_data;
  logic [W-1:0] latched_addr, mcell_out, ext_cs, oe_term, term_defined, pin_in;
  logic [W-1:0] pin_out, pin_oe, imc_bus;

  cfg_io_port #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .latched_addr(latched_addr), .mcell_out(mcell_out),
    .ext_cs(ext_cs), .oe_term(oe_term), .term_defined(term_defined),
    .pin_in(pin_in), .addr_strobe(addr_strobe), .pterm_clk(pterm_clk),
    .imc_clk_sel(imc_clk_sel), .pin_out(pin_out), .pin_oe(pin_oe),
    .imc_bus(imc_bus)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c, d, e;
    logic [7:0] exp;

    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    latched_addr = '0; mcell_out = '0; ext_cs = '0; oe_term = '0;
    term_defined = '0; pin_in = 8'h3C; addr_strobe = 1'b0; pterm_clk = 1'b0;
    imc_clk_sel = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R1 reset state
    for (int o = 1; o <= 6; o++) rd_chk("R1 readback", 3'(o), 8'h00);
    oe_term = 8'hFF; #1;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 imc direct", imc_bus, pin_in);
    oe_term = '0;

    // R2 write and readback
    for (int i = 0; i < 16; i++) begin
      a = 8'((i * 37 + 11) & 8'hFF);
      b = 8'((i * 91 + 5) & 8'hFF);
      wr(3'd1, a);
      wr(3'd2, b);
      rd_chk("R2 dout", 3'd1, a);
      rd_chk("R2 dir", 3'd2, b);
      tick; tick;
      rd_chk("R2 dout hold", 3'd1, a);
    end
    wr(3'd2, 8'h00);

    // R3 uniform selects
    for (int s = 0; s < 4; s++) begin
      wr(3'd3, 8'(s * 8'h55));
      wr(3'd4, 8'(s * 8'h55));
      rd_chk("R3 sel lo", 3'd3, 8'(s * 8'h55));
      rd_chk("R3 sel hi", 3'd4, 8'(s * 8'h55));
      for (int i = 0; i < 12; i++) begin
        a = 8'((i * 29 + 3) & 8'hFF);
        b = 8'((i * 53 + 7) & 8'hFF);
        c = 8'((i * 71 + 13) & 8'hFF);
        d = 8'((i * 17 + 201) & 8'hFF);
        wr(3'd1, a);
        latched_addr = b; mcell_out = c; ext_cs = d;
        #1;
        exp = (s == 0) ? a : (s == 1) ? b : (s == 2) ? c : d;
        chk("R3 uniform select", pin_out, exp);
      end
    end

    // R3 mixed per-pin selects: pin p uses code p%4
    wr(3'd3, 8'hE4);
    wr(3'd4, 8'hE4);
    for (int i = 0; i < 12; i++) begin
      a = 8'((i * 43 + 9) & 8'hFF);
      b = 8'((i * 61 + 2) & 8'hFF);
      c = 8'((i * 83 + 77) & 8'hFF);
      d = 8'((i * 19 + 140) & 8'hFF);
      wr(3'd1, a);
      latched_addr = b; mcell_out = c; ext_cs = d;
      #1;
      for (int p = 0; p < 8; p++) begin
        case (p % 4)
          0: exp[p] = a[p];
          1: exp[p] = b[p];
          2: exp[p] = c[p];
          default: exp[p] = d[p];
        endcase
      end
      chk("R3 mixed select", pin_out, exp);
    end
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);

    // R4 / R5 enable
    for (int i = 0; i < 32; i++) begin
      a = 8'((i * 37 + 1) & 8'hFF);
      b = 8'((i * 59 + 4) & 8'hFF);
      c = 8'((i * 101 + 50) & 8'hFF);
      wr(3'd2, a);
      oe_term = b; term_defined = c;
      #1;
      chk("R4 oe", pin_oe, a | (b & c));
      term_defined = 8'h00;
      #1;
      chk("R5 undefined term", pin_oe, a);
    end
    wr(3'd2, 8'h00);

    // R6 readbacks
    for (int i = 0; i < 8; i++) begin
      pin_in = 8'((i * 47 + 6) & 8'hFF);
      rd_chk("R6 pin readback", 3'd0, pin_in);
      rd_chk("R6 imc readback", 3'd7, pin_in);
    end

    // R7 mode 3 also direct
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    rd_chk("R7 mode lo", 3'd5, 8'hFF);
    pin_in = 8'hA5; #1;
    chk("R7 mode3 direct", imc_bus, 8'hA5);
    pin_in = 8'h5A; #1;
    chk("R7 mode3 direct", imc_bus, 8'h5A);

    // R8 latch mode
    wr(3'd5, 8'h55);
    wr(3'd6, 8'h55);
    addr_strobe = 1'b0;
    pin_in = 8'h11;
    tick;
    addr_strobe = 1'b1; #1;
    chk("R8 transparent", imc_bus, 8'h11);
    tick;
    pin_in = 8'h22; #1;
    chk("R8 transparent follow", imc_bus, 8'h22);
    tick;
    addr_strobe = 1'b0; pin_in = 8'h33; #1;
    chk("R8 hold", imc_bus, 8'h22);
    tick; tick;
    pin_in = 8'h44; #1;
    chk("R8 hold later", imc_bus, 8'h22);

    // R9 register mode
    wr(3'd5, 8'hAA);
    wr(3'd6, 8'hAA);
    rd_chk("R7 mode hi", 3'd6, 8'hAA);
    addr_strobe = 1'b0;
    tick;
    e = imc_bus;
    pin_in = 8'h6D; addr_strobe = 1'b1; #1;
    chk("R9 before edge", imc_bus, e);
    tick;
    chk("R9 captured", imc_bus, 8'h6D);
    pin_in = 8'h92;
    tick; tick;
    chk("R9 hold high", imc_bus, 8'h6D);
    addr_strobe = 1'b0;
    tick;
    chk("R9 hold on fall", imc_bus, 8'h6D);
    addr_strobe = 1'b1;
    tick;
    chk("R9 second rise", imc_bus, 8'h92);

    // R10 strobe source select
    addr_strobe = 1'b0; imc_clk_sel = 1'b1; pterm_clk = 1'b0;
    tick;
    pin_in = 8'hC3;
    addr_strobe = 1'b1; tick; addr_strobe = 1'b0; tick;
    chk("R10 address strobe ignored", imc_bus, 8'h92);
    pterm_clk = 1'b1; tick;
    chk("R10 product term capture", imc_bus, 8'hC3);
    pterm_clk = 1'b0; tick;
    imc_clk_sel = 1'b0;
    tick;
    pin_in = 8'h0F;
    pterm_clk = 1'b1; tick; pterm_clk = 1'b0; tick;
    chk("R10 product term ignored", imc_bus, 8'hC3);
    addr_strobe = 1'b1; tick;
    chk("R10 address strobe capture", imc_bus, 8'h0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule